// File: doc/BRIEF.md
# Decimating Lowpass FIR Filter

This block is a fixed-coefficient lowpass FIR filter that drops the output rate by the decimation ratio. A signed sample enters on every clock. An externally generated single-cycle strobe, one clock in every `DECIM` clocks, marks the output instants. For each marked instant the block delivers the full-precision convolution of the input stream with the tap set. With the default configuration this is 120 taps and a ratio of 20, so one output is produced for every twenty inputs.

Only every `DECIM`-th point of the convolution is needed. The datapath therefore never keeps a sample history. Each arriving sample is multiplied right away by the `NTAPS/DECIM` taps it meets in the outputs still pending. Each product is added into one of a bank of running partial sums, and each partial sum belongs to one future output instant. On a strobe cycle the oldest partial sum is complete, and it leaves through the output register. The remaining sums each move one slot closer to completion, and a cleared sum enters at the far end.

After reset the block ignores its input until the first strobe. The sample taken with that strobe is sample index 0, and all earlier history counts as zero. The output for index 0 covers less than a full period, so it is suppressed. The first reported output is therefore index `DECIM`.

Top module: `dfir_decim`

## Requirements
- R1: On the strobe cycle that takes sample x[n], with n > 0, the block computes y[n] = sum over k = 0..NTAPS-1 of h[k]*x[n-k]. Here h[k] is taps field k, which occupies bits [k*CW +: CW] of `TAPS`. Sample indices count from the first strobe after reset, and samples with a negative index are zero.
- R2: `valid_o` is high for exactly one clock, in the cycle after each strobe cycle except the first one after reset, and `y_o` carries the new result in that same cycle.
- R3: The first strobe after reset produces no `valid_o` pulse. That strobe's output, index 0, is discarded.
- R4: Input samples presented after reset but before the first strobe have no effect on any later output.
- R5: A single clock cycle of `rst_n` low drives `y_o` and `valid_o` to 0 and erases all earlier input history, including in the middle of a run.
- R6: `y_o` is AW = DW + CW + clog2(NTAPS) bits wide and signed. Full-scale constant inputs of either sign give exact results with no wrap.
- R7: When the input is held at zero, the tail outputs continue to match R1 as the earlier samples drain. Once NTAPS samples of zero have been taken, the outputs are zero.
- R8: `y_o` holds its value in every cycle where `valid_o` is low.
- R9: Tap h[0] weights the sample taken in the output's own strobe cycle, and h[k] weights the sample taken k clocks earlier. A unit impulse at index 5 gives outputs h[15], h[35], h[55], and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one input sample per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| x_i | input | DW | Signed two's-complement input sample |
| strobe_i | input | 1 | Single-cycle output-instant marker, one clock in every DECIM |
| y_o | output | DW+CW+clog2(NTAPS) | Signed full-precision filtered output |
| valid_o | output | 1 | High for one clock when `y_o` carries a new result |

## Verification
The scenario that is hardest to produce is the restart edge. It combines a reset in the middle of the stream, noise on the input before the first strobe, and the discarded index-0 output. Each of these is visible only through which later outputs come out right. The stimulus drives nonzero samples with no strobe after each reset, then resets again part-way through a random stream. The scoreboard rebuilds its history from the first strobe after each reset, so any leftover partial sum or early sample shows up as a mismatch. A single impulse at an offset inside a period exposes any error in tap order or phase, and runs of full-scale constant input of each sign test the accumulator width.

// File: rtl/dfir_pkg.sv
package dfir_pkg;

   // Upper bound on the packed tap vector produced by default_taps().
   localparam int MAX_TAP_BITS = 8192;

   // Default coefficient set: a symmetric triangular (crude lowpass) shape,
   // scaled to stay inside the signed tap width.
   function automatic logic [MAX_TAP_BITS-1:0] default_taps(input int ntaps, input int cw);
      logic [MAX_TAP_BITS-1:0] r;
      int                      tri_h;
      int                      val;
      r = '0;
      for (int k = 0; k < ntaps; k++) begin
         tri_h = (k + 1 < ntaps - k) ? (k + 1) : (ntaps - k);
         val   = tri_h * ((1 << (cw - 2)) / (ntaps / 2 + 1));
         for (int b = 0; b < cw; b++) begin
            if (k * cw + b < MAX_TAP_BITS) r[k*cw+b] = val[b];
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/dfir_phase.sv
// Tracks the position inside the output period and whether the first strobe
// since reset has been seen.
module dfir_phase #(
   parameter  int DECIM = 20,
   localparam int QW    = $clog2(DECIM + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe_i,
   output logic [QW-1:0] q_o,
   output logic          armed_o
);

   logic [QW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= QW'(1);
         armed_o <= 1'b0;
      end else begin
         if (strobe_i) begin
            cnt_q   <= QW'(1);
            armed_o <= 1'b1;
         end else if (cnt_q < QW'(DECIM - 1)) begin
            cnt_q <= cnt_q + QW'(1);
         end
      end
   end

   // The strobe cycle is the last phase (DECIM) of the closing period.
   assign q_o = strobe_i ? QW'(DECIM) : cnt_q;

endmodule

// File: rtl/dfir_lane.sv
// One multiplier lane: picks the tap this sample meets in the output that is
// LANE+1 periods (or, on a strobe, LANE periods) away and forms the product.
module dfir_lane #(
   parameter  int                    DW    = 12,
   parameter  int                    CW    = 16,
   parameter  int                    NTAPS = 120,
   parameter  int                    DECIM = 20,
   parameter  int                    LANE  = 0,
   parameter  logic [NTAPS*CW-1:0]   TAPS  = '0,
   localparam int                    QW    = $clog2(DECIM + 1),
   localparam int                    PW    = DW + CW
) (
   input  logic signed [DW-1:0] x_i,
   input  logic        [QW-1:0] q_i,
   output logic signed [PW-1:0] prod_o
);

   int                 kidx;
   logic signed [CW-1:0] tap;

   always_comb begin
      kidx = DECIM * (LANE + 1) - int'(q_i);
      if (kidx < 0)         kidx = 0;
      if (kidx > NTAPS - 1) kidx = NTAPS - 1;
      tap = TAPS[kidx*CW +: CW];
   end

   assign prod_o = PW'(x_i) * PW'(tap);

endmodule

// File: rtl/dfir_decim.sv
module dfir_decim #(
   parameter  int                  DW    = 12,
   parameter  int                  CW    = 16,
   parameter  int                  NTAPS = 120,
   parameter  int                  DECIM = 20,
   parameter  logic [NTAPS*CW-1:0] TAPS  = (NTAPS*CW)'(dfir_pkg::default_taps(NTAPS, CW)),
   localparam int                  NLANE = NTAPS / DECIM,
   localparam int                  PW    = DW + CW,
   localparam int                  AW    = PW + $clog2(NTAPS),
   localparam int                  QW    = $clog2(DECIM + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [DW-1:0] x_i,
   input  logic                 strobe_i,
   output logic signed [AW-1:0] y_o,
   output logic                 valid_o
);

   // ---------------- elaboration-time parameter checks ----------------
   if (NTAPS % DECIM != 0) begin : g_chk_ratio
      $error("NTAPS must be a multiple of DECIM");
   end
   if (DECIM < 2) begin : g_chk_decim
      $error("DECIM must be at least 2");
   end
   if (CW < 2 || CW > 32 || DW < 2) begin : g_chk_width
      $error("DW must be >= 2 and CW in 2..32");
   end

   logic [QW-1:0]        q;
   logic                 armed;
   logic                 run;
   logic signed [PW-1:0] prod_v [NLANE];
   logic signed [AW-1:0] acc_v  [NLANE];

   dfir_phase #(.DECIM(DECIM)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe_i),
      .q_o      (q),
      .armed_o  (armed)
   );

   // Nothing is accumulated until the first strobe defines sample index 0.
   assign run = armed | strobe_i;

   for (genvar j = 0; j < NLANE; j++) begin : g_lane
      logic signed [AW-1:0] acc_q;

      dfir_lane #(
         .DW(DW), .CW(CW), .NTAPS(NTAPS), .DECIM(DECIM), .LANE(j), .TAPS(TAPS)
      ) u_lane (
         .x_i    (x_i),
         .q_i    (q),
         .prod_o (prod_v[j])
      );

      if (j == NLANE - 1) begin : g_tail
         // Far end of the chain: a fresh output starts here on each strobe.
         always_ff @(posedge clk) begin
            if (!rst_n)        acc_q <= '0;
            else if (strobe_i) acc_q <= '0;
            else if (run)      acc_q <= acc_q + AW'(prod_v[j]);
         end
      end else begin : g_body
         // On a strobe each partial sum moves one slot toward completion.
         always_ff @(posedge clk) begin
            if (!rst_n)        acc_q <= '0;
            else if (strobe_i) acc_q <= acc_v[j+1] + AW'(prod_v[j+1]);
            else if (run)      acc_q <= acc_q + AW'(prod_v[j]);
         end
      end

      assign acc_v[j] = acc_q;
   end

   // Output stage: slot 0 plus its final product completes on the strobe.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_o     <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= strobe_i & armed;
         if (strobe_i && armed) y_o <= acc_v[0] + AW'(prod_v[0]);
      end
   end

   // ---------------- assertions ----------------
   AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(strobe_i));                                          // R2

   AST_FIRST_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && !armed) |=> !valid_o);                                    // R3

   AST_UNARMED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (acc_v[0] == '0 && acc_v[NLANE-1] == '0));                  // R4

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && $past(rst_n)) |-> $stable(y_o));                          // R8

endmodule

// File: tb/dfir_decim_tb.sv
module dfir_decim_tb;

   localparam int DW    = 12;
   localparam int CW    = 16;
   localparam int NTAPS = 120;
   localparam int DECIM = 20;
   localparam int AW    = DW + CW + $clog2(NTAPS);

   function automatic longint tb_tap(input int k);
      return longint'((k * 2749 + 311) % 60001) - 30000;
   endfunction

   function automatic logic [NTAPS*CW-1:0] tb_taps();
      logic [NTAPS*CW-1:0] r;
      logic [CW-1:0]       t;
      for (int k = 0; k < NTAPS; k++) begin
         t = CW'(tb_tap(k));
         r[k*CW +: CW] = t;
      end
      return r;
   endfunction

   localparam logic [NTAPS*CW-1:0] TB_TAPS = tb_taps();

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic signed [DW-1:0] x_i = '0;
   logic                 strobe_i = 1'b0;
   logic signed [AW-1:0] y_o;
   logic                 valid_o;

   dfir_decim #(.DW(DW), .CW(CW), .NTAPS(NTAPS), .DECIM(DECIM), .TAPS(TB_TAPS)) u_dut (
      .clk(clk), .rst_n(rst_n), .x_i(x_i), .strobe_i(strobe_i), .y_o(y_o), .valid_o(valid_o)
   );

   always #4 clk = ~clk;   // 125 MHz

   int     checks = 0;
   int     fails  = 0;
   int     pushed = 0;
   int     seen   = 0;
   bit     done   = 0;
   longint hist [8192];
   int     n_m     = 0;
   bit     armed_m = 0;
   longint last_y  = 0;
   string  cur_tag = "R1";
   longint exp_q [$];
   string  tag_q [$];

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic longint conv(input int n);
      longint s = 0;
      for (int k = 0; k < NTAPS; k++) if (n - k >= 0) s += tb_tap(k) * hist[n-k];
      return s;
   endfunction

   // Driver: applies one sample and pushes the expected output for strobes.
   task automatic drive(input longint x, input bit stb);
      @(negedge clk);
      x_i      = DW'(x);
      strobe_i = stb;
      if (armed_m || stb) begin
         hist[n_m] = x;
         if (stb && armed_m) begin
            exp_q.push_back(conv(n_m));
            tag_q.push_back(cur_tag);
            pushed++;
         end
         armed_m = 1;
         n_m++;
      end
   endtask

   // mode: 0 zero, 1 random, 2 full-scale negative, 3 full-scale positive, 4 impulse at index 5
   task automatic period(input int mode);
      logic signed [DW-1:0] r;
      longint               v;
      for (int c = 0; c < DECIM; c++) begin
         r = DW'($urandom);
         case (mode)
            1:       v = longint'(r);
            2:       v = -(longint'(1) << (DW - 1));
            3:       v = (longint'(1) << (DW - 1)) - 1;
            4:       v = (armed_m && n_m == 5) ? 1 : 0;
            default: v = 0;
         endcase
         drive(v, c == 0);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      strobe_i = 1'b0;
      x_i      = '0;
      exp_q.delete();
      tag_q.delete();
      armed_m = 0;
      n_m     = 0;
      last_y  = 0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(y_o == '0, "R5 reset y_o", longint'(y_o), 0);
      check(valid_o == 1'b0, "R5 reset valid_o", longint'(valid_o), 0);
   endtask

   task automatic pre_noise(input int cycles);
      for (int c = 0; c < cycles; c++) drive(longint'(12'sh5A5) - 1000, 1'b0);
   endtask

   // Monitor / scoreboard
   initial begin
      longint e;
      string  t;
      forever begin
         @(posedge clk);
         #2;
         if (rst_n) begin
            if (valid_o) begin
               seen++;
               if (exp_q.size() == 0) begin
                  check(1'b0, "R3 unexpected valid_o", longint'(y_o), 0);
               end else begin
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  check(longint'(y_o) == e, t, longint'(y_o), e);
               end
               last_y = longint'(y_o);
            end else begin
               check(longint'(y_o) == last_y, "R8 hold", longint'(y_o), last_y);
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(8 * 100000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int s0;
      repeat (3) @(negedge clk);
      do_reset();

      // R4: noise before the first strobe must not leak into outputs
      cur_tag = "R4";
      pre_noise(13);
      s0 = seen;
      period(4);
      // R3: first strobe gives no output
      check(seen == s0, "R3 first strobe silent", seen, s0);
      cur_tag = "R9";
      repeat (7) period(4);

      cur_tag = "R1";
      repeat (12) period(1);

      cur_tag = "R6";
      repeat (8) period(2);
      repeat (8) period(3);
      repeat (3) period(2);

      cur_tag = "R7";
      repeat (8) period(0);
      check(last_y == 0, "R7 drained to zero", last_y, 0);

      // Mid-run reset
      cur_tag = "R1";
      repeat (3) period(1);
      @(negedge clk);
      do_reset();
      cur_tag = "R5";
      pre_noise(7);
      repeat (10) period(1);
      cur_tag = "R7";
      repeat (7) period(0);

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R2 all expected outputs seen", exp_q.size(), 0);
      check(seen == pushed, "R2 one valid per strobe", seen, pushed);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule